// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block is a small, fully associative cache of page mappings for a paged memory management unit. A virtual address is split into a page number and an in-page offset. The page number is compared against every stored mapping at once. On a hit, the stored frame number is joined with the unchanged offset to form the physical address. On a miss, a miss flag tells an external table walker to fetch the mapping from memory. The walker then writes the mapping back through the refill port.

Every stored mapping is tagged with the identifier of the process that owns it. A lookup only hits when the entry's tag equals the identifier currently presented, so a context switch needs no flush. Mappings can be dropped all at once, or only those of one process.

Lookup is combinational from the stored state. Refills and flushes take effect at the clock edge.

Top module: `asid_tlb`

## Requirements
- R1: On a hit, `lk_paddr` equals the stored frame number in bits [29:10], with `lk_vaddr[9:0]` copied unchanged into bits [9:0]. The page number is `lk_vaddr[31:10]`.
- R2: A lookup hits only on a valid entry whose page number equals `lk_vaddr[31:10]` and whose identifier equals `cur_asid`. A matching page stored under another identifier misses.
- R3: With `lk_valid` high, exactly one of `lk_hit` and `lk_miss` is high. With `lk_valid` low, both are low.
- R4: When several valid entries match, the frame number comes from the lowest-indexed one, whatever order they were written in.
- R5: A refill writes into the lowest-indexed invalid entry when one exists. In that case the replacement pointer does not move.
- R6: When all 16 entries are valid, a refill overwrites the entry named by a replacement pointer. The pointer then advances by one and wraps from 15 to 0.
- R7: A refilled mapping can hit from the cycle after the refill edge. A lookup of that page in the refill cycle itself reports a miss.
- R8: A cycle with `flush_all` high invalidates every entry.
- R9: A cycle with `flush_id_en` high invalidates only the entries whose identifier equals `flush_id`. All other entries keep hitting.
- R10: After reset every entry is invalid and the replacement pointer is 0.
- R11: When a refill and a flush fall in the same cycle, the victim is chosen from the entries valid before the flush. The flush is applied, and the refilled entry is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Identifier of the running process |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent; walk needed |
| lk_paddr | output | 30 | Physical address, valid with `lk_hit` |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | 22 | Page number of the new mapping |
| fill_pfn | input | 20 | Frame number of the new mapping |
| fill_asid | input | 8 | Owner identifier of the new mapping |
| flush_all | input | 1 | Invalidate all entries |
| flush_id_en | input | 1 | Invalidate the entries of one identifier |
| flush_id | input | 8 | Identifier selected for the targeted flush |

## Verification
After each change to the table, every stored page is looked up under its own identifier with a varying offset. This exposes wrong frame numbers, offset corruption and a lost or misplaced write. The same pages are also looked up under a foreign identifier, together with some absent pages, to tell a tag comparison from a bare page comparison.

Refills are then made into a full table, and the bench checks which older pages disappear. This separates lowest-free placement from round-robin eviction and from pointer wrap. The targeted flush, the global flush and a flush coinciding with a refill each leave a distinct set of surviving pages.

A duplicate page is written at a lower index than an older copy, so that lowest-index selection differs from oldest-entry selection.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 22,
  parameter int OFF_W   = 10,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input  logic [ASID_W-1:0]      cur_asid,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PFN_W+OFF_W-1:0] lk_paddr,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PFN_W-1:0]       fill_pfn,
  input  logic [ASID_W-1:0]      fill_asid,
  input  logic                   flush_all,
  input  logic                   flush_id_en,
  input  logic [ASID_W-1:0]      flush_id
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tvpn  [ENTRIES];
  logic [PFN_W-1:0]   tpfn  [ENTRIES];
  logic [ASID_W-1:0]  tasid [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel, free_idx, victim;
  logic               any_free;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[OFF_W +: VPN_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && tvpn[g] == lk_vpn && tasid[g] == cur_asid;
  end

  always_comb begin
    sel      = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
      if (!vld[i])  free_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&vld;
  assign victim   = any_free ? free_idx : rr;
  assign lk_hit   = lk_valid && |match;
  assign lk_miss  = lk_valid && ~|match;
  assign lk_paddr = {tpfn[sel], lk_vaddr[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      if (flush_all) vld <= '0;
      else if (flush_id_en)
        for (int i = 0; i < ENTRIES; i++)
          if (tasid[i] == flush_id) vld[i] <= 1'b0;
      if (fill_en) begin
        vld[victim] <= 1'b1;
        if (!any_free) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tvpn[victim]  <= fill_vpn;
      tpfn[victim]  <= fill_pfn;
      tasid[victim] <= fill_asid;
    end
  end
endmodule

module asid_tlb_chk #(
  parameter int VPN_W  = 22,
  parameter int OFF_W  = 10,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic [ASID_W-1:0]      cur_asid,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic [PFN_W+OFF_W-1:0] lk_paddr,
  input logic                   fill_en,
  input logic [VPN_W-1:0]       fill_vpn,
  input logic [ASID_W-1:0]      fill_asid,
  input logic                   flush_all,
  input logic                   flush_id_en
);
  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_en) |=> !lk_hit);

  assert_fill_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(fill_en) && !$past(flush_all) && !$past(flush_id_en)
     && lk_vaddr[OFF_W +: VPN_W] == $past(fill_vpn) && cur_asid == $past(fill_asid))
    |-> lk_hit);
endmodule

bind asid_tlb asid_tlb_chk #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .cur_asid(cur_asid), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
  .flush_all(flush_all), .flush_id_en(flush_id_en)
);

// File: tb/asid_tlb_test.sv
`timescale 1ns/1ps
module asid_tlb_test;
  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  cur_asid = '0;
  logic        lk_hit, lk_miss;
  logic [29:0] lk_paddr;
  logic        fill_en = 0;
  logic [21:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [7:0]  fill_asid = '0;
  logic        flush_all = 0, flush_id_en = 0;
  logic [7:0]  flush_id = '0;

  int checks = 0, fails = 0;

  bit          m_v   [16];
  logic [21:0] m_vpn [16];
  logic [19:0] m_pfn [16];
  logic [7:0]  m_asid[16];
  int          m_rr = 0;

  always #5 clk = ~clk;

  asid_tlb uut (.*);

  task automatic look(input logic [21:0] vpn, input logic [9:0] off,
                      input logic [7:0] asid, input string rq);
    int e = -1;
    lk_valid = 1; lk_vaddr = {vpn, off}; cur_asid = asid;
    #1;
    for (int i = 15; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) e = i;
    checks++;
    if (e < 0) begin
      if (lk_hit !== 1'b0 || lk_miss !== 1'b1) begin
        fails++;
        $display("FAIL %s vpn=%h asid=%h: hit=%b miss=%b, expected miss", rq, vpn, asid, lk_hit, lk_miss);
      end
    end else if (lk_hit !== 1'b1 || lk_miss !== 1'b0 || lk_paddr !== {m_pfn[e], off}) begin
      fails++;
      $display("FAIL %s vpn=%h asid=%h: hit=%b pa=%h, expected hit pa=%h", rq, vpn, asid, lk_hit, lk_paddr, {m_pfn[e], off});
    end
  endtask

  task automatic sweep(input string rq);
    for (int i = 0; i < 16; i++) begin
      look(m_vpn[i], 10'(i * 37 + 5), m_asid[i], rq);
      look(m_vpn[i], 10'(i * 11), m_asid[i] ^ 8'h80, "R2");
    end
    look(22'h3ffff0, 10'h3ff, 8'h01, "R2");
    lk_valid = 0;
  endtask

  task automatic step(input bit fe, input logic [21:0] vpn, input logic [19:0] pfn,
                      input logic [7:0] asid, input bit fa, input bit fie,
                      input logic [7:0] fid, input bit same_look);
    int vic = -1;
    bit full;
    @(negedge clk);
    fill_en = fe; fill_vpn = vpn; fill_pfn = pfn; fill_asid = asid;
    flush_all = fa; flush_id_en = fie; flush_id = fid;
    if (same_look) begin
      look(vpn, 10'h2a, asid, "R7");
      lk_valid = 0;
    end
    @(posedge clk);
    for (int i = 15; i >= 0; i--) if (!m_v[i]) vic = i;
    full = (vic < 0);
    if (full) vic = m_rr;
    if (fa) for (int i = 0; i < 16; i++) m_v[i] = 0;
    else if (fie) for (int i = 0; i < 16; i++) if (m_asid[i] == fid) m_v[i] = 0;
    if (fe) begin
      m_v[vic] = 1; m_vpn[vic] = vpn; m_pfn[vic] = pfn; m_asid[vic] = asid;
      if (full) m_rr = (m_rr + 1) % 16;
    end
    #1;
    fill_en = 0; flush_all = 0; flush_id_en = 0;
  endtask

  task automatic fill(input logic [21:0] vpn, input logic [19:0] pfn, input logic [7:0] asid);
    step(1, vpn, pfn, asid, 0, 0, 8'h0, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_asid[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    look(22'h000100, 10'h0, 8'h01, "R10");
    look(22'h000000, 10'h0, 8'h00, "R10");
    lk_valid = 0; #1;
    checks++;
    if (lk_hit !== 0 || lk_miss !== 0) begin
      fails++; $display("FAIL R3 idle: hit=%b miss=%b, expected 0 0", lk_hit, lk_miss);
    end

    for (int i = 0; i < 16; i++)
      step(1, 22'(32'h100 + i), 20'(32'h5000 + i * 3), 8'h01, 0, 0, 8'h0, i == 3);
    sweep("R1");

    for (int k = 0; k < 4; k++) fill(22'(32'h200 + k), 20'(32'h6000 + k), 8'h01);
    sweep("R6");
    for (int k = 0; k < 4; k++) look(22'(32'h100 + k), 10'h1, 8'h01, "R6");

    step(0, '0, '0, '0, 0, 1, 8'h02, 0);
    sweep("R9");
    fill(22'h300, 20'h7777, 8'h02);
    step(0, '0, '0, '0, 0, 1, 8'h01, 0);
    sweep("R9");
    fill(22'h400, 20'h8888, 8'h03);
    sweep("R5");
    fill(22'h300, 20'h9999, 8'h02);
    look(22'h300, 10'h55, 8'h02, "R4");
    sweep("R4");

    step(1, 22'h500, 20'hAAAA, 8'h04, 1, 0, 8'h0, 0);
    sweep("R11");
    fill(22'h501, 20'hAAAB, 8'h05);
    step(1, 22'h502, 20'hAAAC, 8'h06, 0, 1, 8'h04, 0);
    sweep("R11");
    step(0, '0, '0, '0, 1, 0, 8'h0, 0);
    sweep("R8");

    for (int k = 0; k < 40; k++) begin
      fill(22'(32'h1000 + k * 7), 20'(32'h2000 + k * 13), 8'(k % 3));
      if (k % 8 == 7) sweep("R6");
    end
    for (int k = 0; k < 40; k++) look(22'(32'h1000 + k * 7), 10'(k), 8'(k % 3), "R6");
    lk_valid = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule